// File: doc/BRIEF.md
# Triple Trigger Divider

Three divider channels turn external trigger pulses into slower trigger streams for sequencer-style clocking. Each channel passes one input pulse out of every N, with N set per channel anywhere from 1 to 8. The pulse that gets through is the input's own high phase, gated through, so an output pulse is exactly as wide as the input pulse that produced it. A fast system clock runs all the logic. Every external input goes through a two-flop synchronizer first.

Channels 2 and 3 each have a presence flag. While a channel's flag is low, that channel takes its trigger from the channel 1 input. This lets one master trigger feed all three dividers, while either of the other two can still be given a trigger of its own. A shared alignment input realigns all three counters. Each rising edge on it starts a hold window of fixed length, counted in system-clock cycles, and the counters stay at zero for the whole window.

Top module: `trigdiv_top`

## Requirements
- R1: For each channel, `ratio_code` value k (bits [3c+2:3c] for channel c) selects a ratio N = k+1. After a reset or an alignment, the channel emits an output pulse on the N-th, 2N-th, 3N-th, ... rising edge of its trigger, and on no other edge.
- R2: An output pulse stays high for exactly as many system-clock cycles as the input pulse that caused it. It starts a fixed 3 cycles after the input rises.
- R3: A ratio code of 0 (N = 1) passes every input pulse to the output.
- R4: Channel 0 always uses `trig_in[0]`. Channel c (1 or 2) uses `trig_in[c]` when `trig_present[c]` is 1, and uses `trig_in[0]` when it is 0. A trigger line that is not selected has no effect, and `trig_present[0]` has no effect.
- R5: A rising edge on `ext_align` holds all counters at zero for ALIGN_CYCLES cycles. After the hold ends, each channel's next output comes on the N-th trigger edge.
- R6: While the hold is active, every trigger pulse passes through to the output of every channel that sees it.
- R7: A rising edge on `ext_align` that arrives while a hold is active restarts the hold at its full length.
- R8: A new ratio normally takes effect at the next wrap. If the current count is already at or above the new ratio, the count returns to zero at once.
- R9: A synchronous `rst` drives all outputs low, zeroes all counters and ends any active hold.
- R10: The channels count independently. A pulse seen by one channel only does not change the count of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 3 | Asynchronous trigger inputs, one per channel |
| trig_present | input | 3 | Per-input connected flags; bit 0 is unused |
| ext_align | input | 1 | Asynchronous alignment input; acts on its rising edge |
| ratio_code | input | 9 | Three 3-bit ratio codes, channel c at bits [3c+2:3c] |
| div_out | output | 3 | Divided trigger outputs, one per channel |

## Verification
Every ratio from 1 to 8 is swept on every channel, each time paired with different ratios on the other two channels. The input pulse widths cycle from 1 to 4 cycles, and some pulses go to only some channels. This separates a wrong wrap count from a wrong gating window, and it catches channels that are wrongly coupled. Separate patterns drive trigger pulses inside an alignment hold, after a second alignment edge that restarts the hold, and after a ratio change made below and above the current count. These show whether pass-through during the hold, the restart of the hold and the immediate versus deferred ratio change each behave as required. Normalling is tested by driving the channel 1 input alone and then the other inputs alone, under both settings of the presence flags.

// File: rtl/trigdiv_pkg.sv
`timescale 1ns/1ps
package trigdiv_pkg;
    localparam int CH_COUNT = 3;
    localparam int CODE_W   = 3;
    localparam int CNT_W    = CODE_W;
    localparam int RATIO_W  = CODE_W + 1;

    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    typedef struct packed {
        logic prev;
        cnt_t count;
        logic out;
    } chan_st_t;

    function automatic ratio_t code_to_ratio(input logic [CODE_W-1:0] code);
        return ratio_t'(code) + ratio_t'(1);
    endfunction
endpackage

// File: rtl/trigdiv_sync.sv
`timescale 1ns/1ps
module trigdiv_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q = st_q.s2;

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |=> q == $past(st_q.s1)); // R2
endmodule

// File: rtl/trigdiv_align.sv
`timescale 1ns/1ps
module trigdiv_align #(
    parameter int LEN = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic hold
);
    localparam int TW = $clog2(LEN + 1);

    typedef struct packed {
        logic          prev;
        logic [TW-1:0] timer;
    } align_st_t;

    align_st_t st_d, st_q;
    logic      rise;

    always_comb begin
        rise      = lvl & ~st_q.prev;
        st_d      = st_q;
        st_d.prev = lvl;
        if (rise)
            st_d.timer = TW'(LEN);
        else if (st_q.timer != '0)
            st_d.timer = st_q.timer - TW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hold = (st_q.timer != '0);

    AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (rst)
        rise |=> st_q.timer == TW'(LEN)); // R7
    AST_TIMER_DECAY: assert property (@(posedge clk) disable iff (rst)
        (!rise && st_q.timer != '0) |=> st_q.timer == $past(st_q.timer) - TW'(1)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!rise && !hold) |=> !hold); // R5
endmodule

// File: rtl/trigdiv_channel.sv
`timescale 1ns/1ps
module trigdiv_channel
    import trigdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lvl,
    input  logic              hold,
    input  logic [CODE_W-1:0] code,
    output logic              pulse_out
);
    chan_st_t st_d, st_q;
    ratio_t   ratio;
    ratio_t   cnt_ext;
    logic     rise;

    always_comb begin
        ratio   = code_to_ratio(code);
        cnt_ext = {1'b0, st_q.count};
        rise    = lvl & ~st_q.prev;
        st_d      = st_q;
        st_d.prev = lvl;
        if (hold)
            st_d.count = '0;
        else if (rise)
            st_d.count = (cnt_ext + ratio_t'(1) >= ratio) ? '0 : st_q.count + cnt_t'(1);
        else if (cnt_ext >= ratio)
            st_d.count = '0;
        st_d.out = lvl & (st_d.count == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pulse_out = st_q.out;

    AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> $past(lvl)); // R2
    AST_STEP_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (rise && !hold && cnt_ext + ratio_t'(1) < ratio) |=> st_q.count == $past(st_q.count) + cnt_t'(1)); // R1
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!rise && !hold && cnt_ext < ratio) |=> $stable(st_q.count)); // R1
    AST_OVER_RANGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cnt_ext >= ratio) |=> st_q.count == '0); // R8
    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        hold |=> st_q.count == '0); // R5
endmodule

// File: rtl/trigdiv_top.sv
`timescale 1ns/1ps
module trigdiv_top
    import trigdiv_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int ALIGN_CYCLES = CLK_HZ / 1000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CH_COUNT-1:0]        trig_in,
    input  logic [CH_COUNT-1:0]        trig_present,
    input  logic                       ext_align,
    input  logic [CH_COUNT*CODE_W-1:0] ratio_code,
    output logic [CH_COUNT-1:0]        div_out
);
    localparam int SYNC_W = CH_COUNT + 1;

    logic [CH_COUNT-1:0] routed;
    logic [SYNC_W-1:0]   sync_q;
    logic                hold;

    for (genvar k = 0; k < CH_COUNT; k++) begin : g_route
        if (k == 0) begin : g_master
            assign routed[k] = trig_in[0];
        end else begin : g_normal
            assign routed[k] = trig_present[k] ? trig_in[k] : trig_in[0];
        end
    end

    trigdiv_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ext_align, routed}),
        .q   (sync_q)
    );

    trigdiv_align #(.LEN(ALIGN_CYCLES)) u_align (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_q[CH_COUNT]),
        .hold (hold)
    );

    for (genvar k = 0; k < CH_COUNT; k++) begin : g_chan
        trigdiv_channel u_chan (
            .clk       (clk),
            .rst       (rst),
            .lvl       (sync_q[k]),
            .hold      (hold),
            .code      (ratio_code[k*CODE_W +: CODE_W]),
            .pulse_out (div_out[k])
        );
    end

    AST_OUT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (div_out & ~$past(sync_q[CH_COUNT-1:0])) == '0); // R4
endmodule

// File: tb/trigdiv_top_bench.sv
`timescale 1ns/1ps
module trigdiv_top_bench;
    localparam int ALIGN = 40;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] trig_in;
    logic [2:0] trig_present;
    logic       ext_align;
    logic [8:0] ratio_code;
    logic [2:0] div_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cnt [3];
    int rat [3];
    bit hold_m;

    always #10 clk = ~clk;

    trigdiv_top #(.CLK_HZ(50_000_000), .ALIGN_CYCLES(ALIGN)) u_trigdiv_top (
        .clk          (clk),
        .rst          (rst),
        .trig_in      (trig_in),
        .trig_present (trig_present),
        .ext_align    (ext_align),
        .ratio_code   (ratio_code),
        .div_out      (div_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_ratio(input int ch, input int n);
        ratio_code[ch*3 +: 3] = 3'(n - 1);
        rat[ch] = n;
        if (cnt[ch] >= n) cnt[ch] = 0;
    endtask

    task automatic realign();
        ext_align = 1'b1;
        idle(3);
        ext_align = 1'b0;
        idle(ALIGN + 8);
        for (int k = 0; k < 3; k++) cnt[k] = 0;
    endtask

    task automatic align_edge();
        ext_align = 1'b1;
        idle(2);
        ext_align = 1'b0;
    endtask

    // one trigger pulse of w cycles on lines drv; checks every output's high time
    task automatic pulse(input logic [2:0] drv, input int w, input string tag);
        int expw [3];
        int got  [3];
        for (int k = 0; k < 3; k++) begin
            logic seen;
            seen = (k == 0 || trig_present[k]) ? drv[k] : drv[0];
            got[k] = 0;
            expw[k] = 0;
            if (seen) begin
                if (hold_m) expw[k] = w;
                else begin
                    cnt[k] = cnt[k] + 1;
                    if (cnt[k] >= rat[k]) cnt[k] = 0;
                    expw[k] = (cnt[k] == 0) ? w : 0;
                end
            end
        end
        trig_in = drv;
        for (int i = 0; i < w + 8; i++) begin
            @(negedge clk);
            for (int k = 0; k < 3; k++) if (div_out[k]) got[k]++;
            if (i == w - 1) trig_in = 3'b000;
        end
        for (int k = 0; k < 3; k++)
            check(got[k] == expw[k], $sformatf("%s ch%0d", tag, k), got[k], expw[k]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        trig_in = '0;
        trig_present = 3'b111;
        ext_align = 1'b0;
        ratio_code = '0;
        hold_m = 1'b0;
        for (int k = 0; k < 3; k++) begin cnt[k] = 0; rat[k] = 1; end
        idle(4);
        check(div_out == 3'b000, "R9 outputs low in reset", int'(div_out), 0);
        rst = 1'b0;
        idle(2);
        check(div_out == 3'b000, "R9 outputs low after reset", int'(div_out), 0);

        // R1 R2 R3 R10: full ratio sweep, varied widths, partial drives
        for (int n = 1; n <= 8; n++) begin
            trig_present = 3'b111;
            set_ratio(0, n);
            set_ratio(1, (n % 8) + 1);
            set_ratio(2, ((n + 3) % 8) + 1);
            realign();
            for (int i = 0; i < 24; i++) begin
                logic [2:0] drv;
                drv = (i % 5 == 4) ? 3'b101 : ((i % 7 == 6) ? 3'b010 : 3'b111);
                pulse(drv, 1 + (i % 4), "R1 R2 R3 R10 sweep");
            end
        end

        // R4: normalling
        trig_present = 3'b000;
        set_ratio(0, 1); set_ratio(1, 2); set_ratio(2, 3);
        realign();
        for (int i = 0; i < 6; i++) pulse(3'b001, 2 + (i % 3), "R4 normalled from ch0");
        pulse(3'b110, 3, "R4 unselected lines ignored");
        trig_present = 3'b001;
        pulse(3'b001, 2, "R4 present0 no effect");
        trig_present = 3'b110;
        pulse(3'b001, 2, "R4 own inputs selected");
        pulse(3'b110, 2, "R4 own inputs drive");

        // R5 R6: pulses pass during hold, realignment after
        trig_present = 3'b111;
        for (int k = 0; k < 3; k++) set_ratio(k, 4);
        realign();
        pulse(3'b111, 2, "R5 pre-hold");
        align_edge();
        idle(4);
        hold_m = 1'b1;
        for (int i = 0; i < 3; i++) pulse(3'b111, 2, "R6 pass in hold");
        hold_m = 1'b0;
        for (int k = 0; k < 3; k++) cnt[k] = 0;
        idle(30);
        for (int i = 0; i < 8; i++) pulse(3'b111, 1 + (i % 3), "R5 realigned count");

        // R7: restart of hold
        align_edge();
        idle(18);
        align_edge();
        idle(24);
        hold_m = 1'b1;
        pulse(3'b111, 2, "R7 hold restarted");
        hold_m = 1'b0;
        for (int k = 0; k < 3; k++) cnt[k] = 0;
        idle(40);
        pulse(3'b111, 2, "R7 count after restarted hold");

        // R8: ratio change, immediate and deferred
        for (int k = 0; k < 3; k++) set_ratio(k, 8);
        realign();
        for (int i = 0; i < 5; i++) pulse(3'b111, 2, "R8 prefill");
        for (int k = 0; k < 3; k++) set_ratio(k, 4);
        idle(3);
        for (int i = 0; i < 5; i++) pulse(3'b111, 2, "R8 immediate clear");
        for (int k = 0; k < 3; k++) set_ratio(k, 8);
        realign();
        for (int i = 0; i < 2; i++) pulse(3'b111, 2, "R8 prefill2");
        for (int k = 0; k < 3; k++) set_ratio(k, 6);
        idle(3);
        for (int i = 0; i < 5; i++) pulse(3'b111, 3, "R8 deferred wrap");

        // R9: reset mid-count, and reset ending a hold
        for (int k = 0; k < 3; k++) set_ratio(k, 3);
        realign();
        pulse(3'b111, 2, "R9 prefill");
        pulse(3'b111, 2, "R9 prefill");
        rst = 1'b1;
        idle(2);
        check(div_out == 3'b000, "R9 outputs low mid-run reset", int'(div_out), 0);
        rst = 1'b0;
        for (int k = 0; k < 3; k++) cnt[k] = 0;
        idle(2);
        for (int i = 0; i < 3; i++) pulse(3'b111, 2, "R9 count restarts");
        align_edge();
        idle(6);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        for (int k = 0; k < 3; k++) cnt[k] = 0;
        idle(2);
        pulse(3'b111, 2, "R9 reset ends hold");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule